// File: doc/BRIEF.md
# Pipelined Lookahead Reed-Solomon Parity Encoder

This block produces the four check symbols of a shortened Reed-Solomon code with 28 message symbols and 32 codeword symbols over GF(2^8). It does not shift the message through a feedback register one symbol at a time. The whole 28-symbol message arrives in parallel in a single cycle. The message is split into four chunks of seven symbols, and a four-stage feed-forward pipeline folds one chunk per stage into a four-symbol running remainder. Each fold is a fixed GF(2)-linear map, built from constant field multipliers that reduce to XOR networks, so no stage needs a result from a later one.

After the pipeline has filled, the block takes one message per clock and delivers one parity word per clock, with a fixed latency of four clocks. A valid bit follows each message through the stages. The user places the message symbols first and appends the four parity symbols to form a systematic codeword.

Top module: `rs_lapr_enc`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `par_vld_o` and `par_o` to zero and discards every message still in the pipeline; no result for such a message ever appears.
- R2: `par_o` equals the remainder of m(x)·x^4 divided by g(x), where g(x) = (x+α^0)(x+α^1)(x+α^2)(x+α^3). Arithmetic is over GF(2^8) with field polynomial x^8+x^4+x^3+x^2+1 and α = 0x02. Bits [8i+7:8i] of `msg_i` hold the coefficient of x^i of m(x), for i = 0..27. Bits [8j+7:8j] of `par_o` hold the coefficient of x^j of the remainder, for j = 0..3.
- R3: A message sampled with `msg_vld_i` high at a rising edge shows up on `par_o`, with `par_vld_o` high, right after the fourth rising edge, counting the sampling edge as the first.
- R4: Messages presented on consecutive clocks give correct parity words on consecutive clocks, in the same order.
- R5: `par_vld_o` is high exactly four clocks after each valid input and low otherwise, so gaps in the input stream appear unchanged at the output. At most four results are ever in flight.
- R6: When `msg_vld_i` is low, the value on `msg_i` is ignored. `par_o` keeps the last result, and the pipeline stages hold their contents.
- R7: An all-zero message gives an all-zero parity word.
- R8: The codeword c(x) = m(x)·x^4 + p(x), where p(x) is the remainder from `par_o`, evaluates to zero at α^0, α^1, α^2 and α^3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| msg_vld_i | input | 1 | The message on `msg_i` is valid this cycle |
| msg_i | input | 224 | 28 message symbols; symbol i holds the coefficient of x^i |
| par_vld_o | output | 1 | `par_o` carries a new result this cycle |
| par_o | output | 32 | 4 parity symbols; symbol j holds the coefficient of x^j |

## Verification
The assertions assume that `rst` is high from time zero until the first rising edge, and that `msg_vld_i` is low while reset is applied. With those two conditions, the valid-propagation and occupancy properties start from an empty pipeline. The stimulus holds reset for three clocks with the valid line low, and only changes inputs on falling edges. It reasserts reset in the middle of a run only after setting the valid line low in that same cycle. The message field is driven with random values during idle cycles, so that the hold property is tested against real input activity and not against a quiet bus.

// File: rtl/rs_lapr_pkg.sv
package rs_lapr_pkg;

    localparam int SYM_W = 8;
    localparam int NPAR = 4;
    localparam int ROOT_BASE = 0;
    localparam logic [SYM_W:0] FIELD_POLY = 9'h11D;

    typedef logic [SYM_W-1:0] sym_t;
    typedef logic [NPAR-1:0][SYM_W-1:0] rem_t;
    typedef logic [SYM_W-1:0][SYM_W-1:0] col_t;

    // General field product; called only at elaboration with a constant operand.
    function automatic sym_t gf_mul(input sym_t a, input sym_t b);
        sym_t acc;
        sym_t sh;
        acc = '0;
        sh = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            if (sh[SYM_W-1]) sh = (sh << 1) ^ FIELD_POLY[SYM_W-1:0];
            else             sh = sh << 1;
        end
        return acc;
    endfunction

    function automatic sym_t alpha_pow(input int n);
        sym_t r;
        r = sym_t'(1);
        for (int i = 0; i < n; i++) r = gf_mul(r, sym_t'(2));
        return r;
    endfunction

    // Low coefficients of the monic generator; the leading 1 is implicit.
    function automatic rem_t gen_low();
        sym_t g [0:NPAR];
        sym_t root;
        rem_t res;
        for (int j = 0; j <= NPAR; j++) g[j] = '0;
        g[0] = sym_t'(1);
        for (int i = 0; i < NPAR; i++) begin
            root = alpha_pow(ROOT_BASE + i);
            for (int j = NPAR; j > 0; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
            g[0] = gf_mul(g[0], root);
        end
        for (int j = 0; j < NPAR; j++) res[j] = g[j];
        return res;
    endfunction

    // x^p reduced modulo the generator: the lookahead coefficient set for degree p.
    function automatic rem_t xpow_mod(input int p);
        rem_t gl;
        rem_t r;
        sym_t top;
        gl = gen_low();
        r = '0;
        r[0] = sym_t'(1);
        for (int s = 0; s < p; s++) begin
            top = r[NPAR-1];
            for (int j = NPAR - 1; j > 0; j--) r[j] = r[j-1] ^ gf_mul(top, gl[j]);
            r[0] = gf_mul(top, gl[0]);
        end
        return r;
    endfunction

    // Column a of the bit matrix that multiplies by a constant.
    function automatic col_t cmul_cols(input sym_t coef);
        col_t c;
        for (int a = 0; a < SYM_W; a++) c[a] = gf_mul(coef, sym_t'(1) << a);
        return c;
    endfunction

endpackage

// File: rtl/rs_lapr_cmul.sv
module rs_lapr_cmul
    import rs_lapr_pkg::*;
#(
    parameter sym_t COEF = 8'h01
) (
    input  sym_t a_i,
    output sym_t p_o
);

    localparam col_t COL = cmul_cols(COEF);

    // AND with constants plus XOR: folds to a pure XOR network.
    always_comb begin
        p_o = '0;
        for (int a = 0; a < SYM_W; a++) begin
            if (a_i[a]) p_o = p_o ^ COL[a];
        end
    end

endmodule

// File: rtl/rs_lapr_fold.sv
module rs_lapr_fold
    import rs_lapr_pkg::*;
#(
    parameter int CHUNK = 7
) (
    input  rem_t                          rem_i,
    input  logic [CHUNK-1:0][SYM_W-1:0]   chunk_i,
    output rem_t                          rem_o
);

    localparam int NDEG = CHUNK + NPAR;

    sym_t coef_d [NDEG];
    sym_t prod   [NDEG][NPAR];

    // Merge rem*x^CHUNK and chunk*x^NPAR by degree, then reduce each degree
    // with its precomputed x^d mod g vector.
    for (genvar d = 0; d < NDEG; d++) begin : g_deg
        sym_t from_chunk;
        sym_t from_rem;
        localparam rem_t XP = xpow_mod(d);

        if (d >= NPAR) begin : g_c
            assign from_chunk = chunk_i[d-NPAR];
        end else begin : g_nc
            assign from_chunk = '0;
        end

        if (d >= CHUNK) begin : g_r
            assign from_rem = rem_i[d-CHUNK];
        end else begin : g_nr
            assign from_rem = '0;
        end

        assign coef_d[d] = from_chunk ^ from_rem;

        for (genvar o = 0; o < NPAR; o++) begin : g_out
            rs_lapr_cmul #(.COEF(XP[o])) u_cmul (
                .a_i (coef_d[d]),
                .p_o (prod[d][o])
            );
        end
    end

    always_comb begin
        for (int o = 0; o < NPAR; o++) begin
            rem_o[o] = '0;
            for (int d = 0; d < NDEG; d++) rem_o[o] = rem_o[o] ^ prod[d][o];
        end
    end

endmodule

// File: rtl/rs_lapr_stage.sv
module rs_lapr_stage
    import rs_lapr_pkg::*;
#(
    parameter int CHUNK = 7
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         vld_i,
    input  rem_t                         rem_i,
    input  logic [CHUNK-1:0][SYM_W-1:0]  chunk_i,
    output logic                         vld_o,
    output rem_t                         rem_o
);

    rem_t rem_nx;

    rs_lapr_fold #(.CHUNK(CHUNK)) u_fold (
        .rem_i   (rem_i),
        .chunk_i (chunk_i),
        .rem_o   (rem_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            rem_o <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) rem_o <= rem_nx;
        end
    end

    // R5
    vld_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> vld_o);

    // R5
    vld_gap_chk: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> !vld_o);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> $stable(rem_o));

    // R7
    zero_in_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_i && rem_i == '0 && chunk_i == '0) |=> rem_o == '0);

endmodule

// File: rtl/rs_lapr_enc.sv
module rs_lapr_enc
    import rs_lapr_pkg::*;
#(
    parameter int MSG_LEN = 28,
    parameter int STAGES  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      msg_vld_i,
    input  logic [MSG_LEN*SYM_W-1:0]  msg_i,
    output logic                      par_vld_o,
    output logic [NPAR*SYM_W-1:0]     par_o
);

    localparam int CHUNK = MSG_LEN / STAGES;
    localparam int CW    = $clog2(STAGES + 1) + 1;

    typedef logic [CHUNK-1:0][SYM_W-1:0] chunk_t;

    logic [MSG_LEN-1:0][SYM_W-1:0] msg_s;
    logic [STAGES:0]               vld_s;
    rem_t                          rem_s    [STAGES+1];
    chunk_t                        chunk_al [STAGES];

    assign msg_s    = msg_i;
    assign vld_s[0] = msg_vld_i;
    assign rem_s[0] = '0;

    for (genvar k = 0; k < STAGES; k++) begin : g_lane
        chunk_t head;
        // Highest-degree chunk enters first.
        assign head = msg_s[MSG_LEN-1-k*CHUNK -: CHUNK];

        if (k == 0) begin : g_direct
            assign chunk_al[k] = head;
        end else begin : g_skew
            chunk_t sr [k];
            // Skew register j moves with the valid bit of pipeline position j.
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < k; i++) sr[i] <= '0;
                end else begin
                    if (vld_s[0]) sr[0] <= head;
                    for (int i = 1; i < k; i++) begin
                        if (vld_s[i]) sr[i] <= sr[i-1];
                    end
                end
            end
            assign chunk_al[k] = sr[k-1];
        end

        rs_lapr_stage #(.CHUNK(CHUNK)) u_stage (
            .clk     (clk),
            .rst     (rst),
            .vld_i   (vld_s[k]),
            .rem_i   (rem_s[k]),
            .chunk_i (chunk_al[k]),
            .vld_o   (vld_s[k+1]),
            .rem_o   (rem_s[k+1])
        );
    end

    assign par_vld_o = vld_s[STAGES];
    assign par_o     = rem_s[STAGES];

    // Occupancy bookkeeping for the checks below.
    logic [CW-1:0] inflight;
    always_ff @(posedge clk) begin
        if (rst) inflight <= '0;
        else     inflight <= inflight + CW'(msg_vld_i) - CW'(par_vld_o);
    end

    // R5
    occupancy_chk: assert property (@(posedge clk) disable iff (rst)
        inflight <= CW'(STAGES));

    // R5
    no_orphan_chk: assert property (@(posedge clk) disable iff (rst)
        par_vld_o |-> inflight != '0);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!par_vld_o && par_o == '0));

endmodule

// File: tb/rs_lapr_enc_tb.sv
module rs_lapr_enc_tb;

    localparam int ML  = 28;
    localparam int NP  = 4;
    localparam int LAT = 4;
    localparam int QN  = 9000;

    logic            clk;
    logic            rst;
    logic            msg_vld_i;
    logic [ML*8-1:0] msg_i;
    logic            par_vld_o;
    logic [NP*8-1:0] par_o;

    rs_lapr_enc u_dut (
        .clk       (clk),
        .rst       (rst),
        .msg_vld_i (msg_vld_i),
        .msg_i     (msg_i),
        .par_vld_o (par_vld_o),
        .par_o     (par_o)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int wr = 0;
    int rd = 0;
    logic [ML*8-1:0] exp_msg [QN];
    logic [NP*8-1:0] exp_par [QN];
    int              exp_cyc [QN];
    logic [7:0]      gb [0:NP];

    function automatic logic [7:0] tmul(logic [7:0] a, logic [7:0] b);
        logic [7:0] acc = 0;
        logic [7:0] s = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc ^= s;
            s = s[7] ? ((s << 1) ^ 8'h1D) : (s << 1);
        end
        return acc;
    endfunction

    function automatic logic [7:0] tpow(int n);
        logic [7:0] r = 8'h01;
        for (int i = 0; i < n; i++) r = tmul(r, 8'h02);
        return r;
    endfunction

    // Symbol-serial feedback-register model of the division.
    function automatic logic [NP*8-1:0] ref_parity(logic [ML*8-1:0] m);
        logic [7:0] r [NP];
        logic [7:0] fb;
        logic [NP*8-1:0] out;
        for (int j = 0; j < NP; j++) r[j] = 0;
        for (int i = ML - 1; i >= 0; i--) begin
            fb = m[8*i +: 8] ^ r[NP-1];
            for (int j = NP - 1; j > 0; j--) r[j] = r[j-1] ^ tmul(fb, gb[j]);
            r[0] = tmul(fb, gb[0]);
        end
        for (int j = 0; j < NP; j++) out[8*j +: 8] = r[j];
        return out;
    endfunction

    function automatic logic [7:0] eval_cw(logic [ML*8-1:0] m, logic [NP*8-1:0] p, logic [7:0] x);
        logic [7:0] acc = 0;
        logic [7:0] c;
        for (int d = ML + NP - 1; d >= 0; d--) begin
            c = (d >= NP) ? m[8*(d-NP) +: 8] : p[8*d +: 8];
            acc = tmul(acc, x) ^ c;
        end
        return acc;
    endfunction

    function automatic logic [ML*8-1:0] rand_msg();
        logic [ML*8-1:0] m;
        for (int i = 0; i < ML; i++) m[8*i +: 8] = 8'($urandom);
        return m;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [ML*8-1:0] m);
        @(negedge clk);
        msg_i = m;
        msg_vld_i = 1'b1;
        exp_msg[wr] = m;
        exp_par[wr] = ref_parity(m);
        exp_cyc[wr] = cyc;
        wr++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            msg_vld_i = 1'b0;
            msg_i = rand_msg();
        end
    endtask

    // Output monitor: value (R2/R4), latency (R3), codeword roots (R8).
    always @(negedge clk) begin
        if (par_vld_o) begin
            if (rd >= wr) begin
                check(1'b0, "R5", "valid without pending message", 256'(par_vld_o), 256'(0));
            end else begin
                check(par_o == exp_par[rd], "R2", "parity value", 256'(par_o), 256'(exp_par[rd]));
                check(cyc == exp_cyc[rd] + LAT, "R3", "latency", 256'(cyc - exp_cyc[rd]), 256'(LAT));
                for (int i = 0; i < NP; i++)
                    check(eval_cw(exp_msg[rd], par_o, tpow(i)) == 8'h00, "R8", "codeword root",
                          256'(eval_cw(exp_msg[rd], par_o, tpow(i))), 256'(0));
                rd++;
            end
        end
    end

    initial begin
        logic [NP*8-1:0] held;
        rst = 1'b1;
        msg_vld_i = 1'b0;
        msg_i = '0;
        for (int j = 0; j <= NP; j++) gb[j] = 0;
        gb[0] = 8'h01;
        for (int i = 0; i < NP; i++)
            for (int j = NP; j >= 0; j--)
                gb[j] = (j > 0 ? gb[j-1] : 8'h00) ^ tmul(gb[j], tpow(i));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(par_vld_o == 1'b0, "R1", "valid after reset", 256'(par_vld_o), 256'(0));
        check(par_o == '0, "R1", "parity after reset", 256'(par_o), 256'(0));

        // R7: all-zero message, then all-ones
        send('0);
        idle(LAT + 1);
        check(exp_par[0] == '0 && rd == 1, "R7", "zero message parity", 256'(exp_par[0]), 256'(0));
        send({ML{8'hFF}});

        // R4: back-to-back sweep of every symbol position and every nonzero value
        for (int pos = 0; pos < ML; pos++)
            for (int v = 1; v < 256; v++)
                send((ML*8)'(v) << (8 * pos));

        // R5: random messages with random gaps
        for (int n = 0; n < 600; n++) begin
            if ($urandom_range(1, 0) == 1) send(rand_msg());
            else idle(1);
        end

        // R6: drain, then garbage with valid low must not disturb the output
        idle(LAT + 2);
        check(rd == wr, "R5", "all results delivered", 256'(rd), 256'(wr));
        held = par_o;
        check(held == exp_par[wr-1], "R6", "last result held", 256'(held), 256'(exp_par[wr-1]));
        for (int i = 0; i < 10; i++) begin
            idle(1);
            check(par_o == held && !par_vld_o, "R6", "ignored input", 256'(par_o), 256'(held));
        end

        // R1: reset with two messages in flight discards them
        send(rand_msg());
        send(rand_msg());
        @(negedge clk);
        msg_vld_i = 1'b0;
        rst = 1'b1;
        rd = wr;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < LAT + 2; i++) begin
            idle(1);
            check(par_o == '0 && !par_vld_o, "R1", "in-flight discarded", 256'(par_o), 256'(0));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule